// File: doc/BRIEF.md
# Multi-Channel Input Capture Timer

This block is a timer peripheral built around a 16-bit free-running counter and a set of input capture channels. Every channel samples an asynchronous pin through a two-stage synchronizer and compares each new sample with the one before it to find edges. When the edge matches the channel's configured polarity, the channel stores the counter in its capture register and raises its pending flag in the same clock. Channels that fire in the same cycle store the same counter value.

Flags stay pending until software clears them, whatever the interrupt enables are set to. A flag is cleared by writing 1 to its bit. In fast-clear mode, a strobed read of the channel's capture register also clears it. A channel can be locked so that its capture register cannot change while its flag is pending. Without the lock, every new edge overwrites the register. The interrupt request is raised when any pending flag is also enabled, and it comes with the index of the lowest-numbered such channel. Software reaches the configuration, flags, counter and captures through a flat register port. Reads return data combinationally. Writes, and read strobes, take effect at the next clock edge.

Top module: `capture_timer`

## Requirements
- R1: The counter resets to 0, rises by one on every clock and wraps from 0xFFFF to 0. The wrap sets the overflow flag, which is bit 15 of the flag register, in the same edge where the counter becomes 0. Writing 1 to bit 15 clears the overflow flag.
- R2: The register map is 0 = control (bit 0 = fast-clear mode), 1 = edge select, 2 = interrupt enable (bit i = channel i), 3 = overwrite lock (bit i = channel i), 4 = flags (bit i = channel i), 5 = counter (read only), 8+i = capture register of channel i. In the edge select register, field bits [2i+1:2i] set channel i to 0 = disabled, 1 = rising, 2 = falling or 3 = both edges.
- R3: A pin change that is applied during the cycle in which the counter reads C, and that matches the selected edge, loads C+2 (mod 2^16) into the capture register. The channel's flag then reads as set after the third rising clock edge. A change that does not match leaves both the capture register and the flag unchanged.
- R4: When several channels see active edges in the same cycle, all of them store the same counter value and set their flags together.
- R5: A set flag remains set until it is cleared, whatever the interrupt enables are set to. Writing 1 to a flag bit clears it. Writing 0 has no effect.
- R6: With the lock off, each active edge overwrites the capture register even while the flag is still pending.
- R7: With a channel's lock on and its flag set, active edges leave its capture register unchanged. After the flag is cleared, the next edge captures normally.
- R8: With fast-clear mode on, a read of capture register i with the read strobe asserted clears flag i and no other flag. With fast-clear mode off, or with the read strobe low, reads leave the flags unchanged.
- R9: irqValid is high exactly when some flag and its enable bit are both set. irqIdx gives the lowest channel index that meets this condition.
- R10: After reset, the configuration, the flags and all capture registers read 0, and irqValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capPins | input | NUM_CH | Asynchronous capture inputs, one per channel |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | CNT_W | Write data |
| regRdEn | input | 1 | Read strobe; triggers fast clear |
| regRdData | output | CNT_W | Combinational read data for regAddr |
| irqValid | output | 1 | Interrupt request |
| irqIdx | output | IDX_W | Index of the highest-priority pending channel |

## Verification
The bench changes a pin just after a falling clock edge and reads the counter in that same half-cycle. The two synchronizer stages and the edge stage put the capture and the flag three rising edges later, with the value C+2. The bench therefore samples at the falling edge that follows those three rising edges. Register writes and strobed reads land on the next rising edge, so their effects are read at the falling edge after it. The overflow flag is polled at every falling edge, and the counter must read exactly 0 the first time the flag appears.

// File: rtl/capPkg.sv
package capPkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeSel_e;

  // per-channel strobe bundle from control to datapath
  typedef struct packed {
    logic     load;
    edgeSel_e mode;
  } chStrobe_t;

  localparam int REG_CTRL  = 0;
  localparam int REG_EDGE  = 1;
  localparam int REG_IEN   = 2;
  localparam int REG_LOCK  = 3;
  localparam int REG_FLAGS = 4;
  localparam int REG_COUNT = 5;
  localparam int REG_CAP0  = 8;
endpackage

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_CH-1:0] pins,
  input  chStrobe_t        strobes [NUM_CH],
  output logic [NUM_CH-1:0] hit,
  output logic             wrap,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal [NUM_CH]
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= count + 1'b1;
  end

  assign wrap = &count;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic meta, syncd, prev;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta  <= 1'b0;
        syncd <= 1'b0;
        prev  <= 1'b0;
      end else begin
        meta  <= pins[g];
        syncd <= meta;
        prev  <= syncd;
      end
    end

    always_comb begin
      case (strobes[g].mode)
        EDGE_RISE: hit[g] = syncd & ~prev;
        EDGE_FALL: hit[g] = ~syncd & prev;
        EDGE_BOTH: hit[g] = syncd ^ prev;
        default:   hit[g] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                capVal[g] <= '0;
      else if (strobes[g].load) capVal[g] <= count;
    end
  end
endmodule

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hit,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capVal [NUM_CH],
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [CNT_W-1:0]  rdData,
  output chStrobe_t         strobes [NUM_CH],
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqIdx,
  output logic [NUM_CH-1:0] flagsOut,
  output logic [NUM_CH-1:0] ienOut,
  output logic [NUM_CH-1:0] lockOut
);
  localparam int EDGE_W  = 2 * NUM_CH;
  localparam int OVF_BIT = CNT_W - 1;

  logic              fastClr;
  logic [EDGE_W-1:0] edgeCfg;
  logic [NUM_CH-1:0] ien, lock, flags, clrVec, pend;
  logic              ovfFlag, ovfClr, wrFlags;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign wrFlags      = wrEn && (regAddr == ADDR_W'(REG_FLAGS));
  assign ovfClr       = wrFlags && wrData[OVF_BIT];

  always_comb begin
    clrVec = wrFlags ? wrData[NUM_CH-1:0] : '0;
    for (int i = 0; i < NUM_CH; i++)
      if (fastClr && rdEn && (regAddr == ADDR_W'(REG_CAP0 + i))) clrVec[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastClr <= 1'b0;
      edgeCfg <= '0;
      ien     <= '0;
      lock    <= '0;
      flags   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        case (regAddr)
          ADDR_W'(REG_CTRL): fastClr <= wrData[0];
          ADDR_W'(REG_EDGE): edgeCfg <= wrData[EDGE_W-1:0];
          ADDR_W'(REG_IEN):  ien     <= wrData[NUM_CH-1:0];
          ADDR_W'(REG_LOCK): lock    <= wrData[NUM_CH-1:0];
          default: ;
        endcase
      end
      flags   <= (flags & ~clrVec) | hit;
      ovfFlag <= wrap | (ovfFlag & ~ovfClr);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gStb
    assign strobes[g].mode = edgeSel_e'(edgeCfg[2*g +: 2]);
    assign strobes[g].load = hit[g] & ~(lock[g] & flags[g]);
  end

  assign pend = flags & ien;

  always_comb begin
    irqIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend[i]) irqIdx = IDX_W'(i);
    irqValid = |pend;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_W'(REG_CTRL):  rdData[0] = fastClr;
      ADDR_W'(REG_EDGE):  rdData[EDGE_W-1:0] = edgeCfg;
      ADDR_W'(REG_IEN):   rdData[NUM_CH-1:0] = ien;
      ADDR_W'(REG_LOCK):  rdData[NUM_CH-1:0] = lock;
      ADDR_W'(REG_FLAGS): begin
        rdData[NUM_CH-1:0] = flags;
        rdData[OVF_BIT]    = ovfFlag;
      end
      ADDR_W'(REG_COUNT): rdData = count;
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (regAddr == ADDR_W'(REG_CAP0 + i)) rdData = capVal[i];
      end
    endcase
  end

  assign flagsOut = flags;
  assign ienOut   = ien;
  assign lockOut  = lock;
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import capPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] capPins,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [CNT_W-1:0]  regRdData,
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqIdx
);
  chStrobe_t         strobes [NUM_CH];
  logic [NUM_CH-1:0] hit, chFlags, irqEn, lockEn;
  logic              wrap;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  capVal [NUM_CH];

  capDatapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .pins(capPins), .strobes(strobes),
    .hit(hit), .wrap(wrap), .count(cntVal), .capVal(capVal)
  );

  capCtrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hit(hit), .wrap(wrap), .count(cntVal), .capVal(capVal),
    .regAddr(regAddr), .wrEn(regWrEn), .wrData(regWrData), .rdEn(regRdEn),
    .rdData(regRdData), .strobes(strobes), .irqValid(irqValid), .irqIdx(irqIdx),
    .flagsOut(chFlags), .ienOut(irqEn), .lockOut(lockEn)
  );
endmodule

// File: rtl/capChecker.sv
module capChecker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  capVal [NUM_CH],
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] ien,
  input logic [NUM_CH-1:0] lock,
  input logic              irqValid,
  input logic [IDX_W-1:0]  irqIdx,
  input logic              wrEn,
  input logic              rdEn
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> count == CNT_W'($past(count) + 1'b1));

  assert_irq_prio_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (flags[irqIdx] && ien[irqIdx] &&
      (((flags & ien) & ((NUM_CH'(1) << irqIdx) - NUM_CH'(1))) == '0)));

  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> ((flags & ien) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    assert_cap_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && (capVal[g] != $past(capVal[g]))) |-> flags[g]);

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(lock[g] && flags[g])) |-> capVal[g] == $past(capVal[g]));

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(flags[g]) && !flags[g]) |-> $past(wrEn || rdEn));
  end
endmodule

bind capture_timer capChecker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .count(cntVal), .capVal(capVal), .flags(chFlags),
  .ien(irqEn), .lock(lockEn), .irqValid(irqValid), .irqIdx(irqIdx),
  .wrEn(regWrEn), .rdEn(regRdEn)
);

// File: tb/test_capture_timer.sv
module test_capture_timer;
  localparam int N = 4;
  localparam logic [3:0] A_CTRL = 4'd0, A_EDGE = 4'd1, A_IEN = 4'd2, A_LOCK = 4'd3,
                         A_FLAGS = 4'd4, A_CNT = 4'd5, A_CAP0 = 4'd8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] pins = '0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqValid;
  logic [1:0]  irqIdx;
  int checks = 0, errors = 0;
  logic [15:0] expCap [N];

  always #2 clk = ~clk;

  capture_timer i_capture_timer (
    .clk(clk), .rstN(rstN), .capPins(pins), .regAddr(addr), .regWrEn(wrEn),
    .regWrData(wrData), .regRdEn(rdEn), .regRdData(rdData),
    .irqValid(irqValid), .irqIdx(irqIdx)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    rdEn = 1'b0; addr = a; #1; d = rdData;
  endtask

  task automatic strobedRead(input logic [3:0] a);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // drive new pin levels, return counter value of that cycle, wait for result
  task automatic edgeAt(input logic [N-1:0] nv, output logic [15:0] c);
    @(negedge clk); pins = nv; addr = A_CNT; #1; c = rdData;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(input logic [N-1:0] lvl);
    wr(A_EDGE, 16'h0);
    @(negedge clk); pins = lvl;
    repeat (4) @(negedge clk);
    wr(A_FLAGS, 16'hFFFF);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, c, c2;
    bit seen;
    for (int i = 0; i < N; i++) expCap[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    peek(A_FLAGS, d); check("R10 flags", d, 16'h0);
    peek(A_EDGE, d);  check("R10 edge cfg", d, 16'h0);
    peek(A_CAP0, d);  check("R10 cap0", d, 16'h0);
    check("R10 irqValid", {15'b0, irqValid}, 16'h0);

    // R1: counter steps by one
    peek(A_CNT, c); @(negedge clk); peek(A_CNT, d);
    check("R1 count step", d, c + 16'd1);

    // R2/R3: sweep channel x edge mode x transition direction
    for (int ch = 0; ch < N; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [N-1:0] lvl;
          bit act;
          lvl = (dir == 0) ? '0 : '1;
          settle(lvl);
          wr(A_EDGE, 16'(m) << (2 * ch));
          edgeAt(lvl ^ (N'(1) << ch), c);
          act = (m == 3) || (m == 1 && dir == 0) || (m == 2 && dir == 1);
          if (act) expCap[ch] = c + 16'd2;
          peek(A_FLAGS, d);
          check($sformatf("R2 R3 flag ch%0d mode%0d dir%0d", ch, m, dir),
                d & 16'h000F, act ? (16'd1 << ch) : 16'd0);
          peek(A_CAP0 + 4'(ch), d);
          check($sformatf("R3 cap ch%0d mode%0d dir%0d", ch, m, dir), d, expCap[ch]);
        end
      end
    end

    // R4: simultaneous falling edges on all channels
    settle('1);
    wr(A_EDGE, 16'h00AA);
    edgeAt('0, c);
    peek(A_FLAGS, d); check("R4 all flags", d & 16'h000F, 16'h000F);
    for (int i = 0; i < N; i++) begin
      peek(A_CAP0 + 4'(i), d);
      check($sformatf("R4 cap%0d", i), d, c + 16'd2);
    end

    // R9: priority and enable gating
    wr(A_IEN, 16'h000F);
    check("R9 valid", {15'b0, irqValid}, 16'h1);
    check("R9 idx0", {14'b0, irqIdx}, 16'h0);
    // R5: writing zero does nothing
    wr(A_FLAGS, 16'h0000);
    peek(A_FLAGS, d); check("R5 write0", d & 16'h000F, 16'h000F);
    wr(A_FLAGS, 16'h0001);
    peek(A_FLAGS, d); check("R5 write1 clears", d & 16'h000F, 16'h000E);
    check("R9 idx1", {14'b0, irqIdx}, 16'h1);
    wr(A_IEN, 16'h000C);
    check("R9 idx2", {14'b0, irqIdx}, 16'h2);
    wr(A_IEN, 16'h0000);
    check("R9 masked", {15'b0, irqValid}, 16'h0);
    peek(A_FLAGS, d); check("R5 held while masked", d & 16'h000F, 16'h000E);

    // R8: fast clear
    strobedRead(A_CAP0 + 4'd1);
    peek(A_FLAGS, d); check("R8 mode off no clear", d & 16'h000F, 16'h000E);
    wr(A_CTRL, 16'h0001);
    strobedRead(A_CAP0 + 4'd1);
    peek(A_FLAGS, d); check("R8 read clears ch1", d & 16'h000F, 16'h000C);
    @(negedge clk); peek(A_CAP0 + 4'd2, d);
    @(negedge clk); peek(A_FLAGS, d); check("R8 no strobe no clear", d & 16'h000F, 16'h000C);
    wr(A_CTRL, 16'h0000);

    // R6: overwrite while pending
    settle('0);
    wr(A_EDGE, 16'h0003);
    edgeAt(4'b0001, c);
    peek(A_CAP0, d); check("R6 first capture", d, c + 16'd2);
    repeat (5) @(negedge clk);
    edgeAt(4'b0000, c2);
    peek(A_CAP0, d); check("R6 overwritten", d, c2 + 16'd2);
    peek(A_FLAGS, d); check("R6 flag still set", d & 16'h000F, 16'h0001);

    // R7: lock
    wr(A_LOCK, 16'h0001);
    edgeAt(4'b0001, c);
    peek(A_CAP0, d); check("R7 locked capture", d, c2 + 16'd2);
    peek(A_FLAGS, d); check("R7 flag set", d & 16'h000F, 16'h0001);
    wr(A_FLAGS, 16'h0001);
    edgeAt(4'b0000, c);
    peek(A_CAP0, d); check("R7 capture after clear", d, c + 16'd2);
    wr(A_LOCK, 16'h0000);

    // R1: wrap and overflow flag
    wr(A_FLAGS, 16'hFFFF);
    seen = 1'b0;
    for (int k = 0; k < 70000 && !seen; k++) begin
      @(negedge clk);
      peek(A_FLAGS, d);
      if (d[15]) begin
        seen = 1'b1;
        peek(A_CNT, c);
        check("R1 count zero at overflow", c, 16'h0);
      end
    end
    check("R1 overflow seen", {15'b0, seen}, 16'h1);
    wr(A_FLAGS, 16'h8000);
    peek(A_FLAGS, d); check("R1 overflow cleared", d & 16'h8000, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule